// File: doc/BRIEF.md
# Binary64 to Signed 64-bit Integer Truncating Converter

This block takes a 64-bit IEEE-754 double-precision operand and produces a 64-bit two's-complement integer, always rounding toward zero. It does not saturate when the value is out of range. Instead it returns the exact integer wrapped to its low 64 bits, so very large operands give the integer value modulo 2^64. Alongside the result it produces a 64-bit status word. Inside that word, three flags sit at fixed positions: invalid operation, integer overflow and inexact.

The unit has one register stage. The caller presents an operand together with a valid strobe. One clock later the result and status appear with a done pulse, and they stay unchanged until the next valid. A small two-state controller sequences the strobe. State `ST_WAIT` means no fresh result and `ST_DONE` means a result was captured on the last edge. The transition `WAIT->DONE` is taken on valid, `DONE->DONE` on a back-to-back valid, and `DONE->WAIT` when valid is low. `WAIT->WAIT` holds while idle.

Top module: `f2i_trunc_conv`

## Requirements
- R1: The operand uses the binary64 layout: sign at bit 63, an 11-bit exponent at bits 62:52 with bias 1023, and the fraction at bits 51:0. Finite values that are integral and whose magnitude is below 2^63 convert exactly (1.0 gives 1, -1.0 gives all ones, 2^32 gives 0x0000000100000000), and the status word is zero.
- R2: A finite value with a fractional part is truncated toward zero (1.5 gives 1, -2.75 gives -2) and only the inexact flag is set.
- R3: -2^63 converts to 0x8000000000000000 with no flags.
- R4: Any other finite value with an unbiased exponent of 63 or more returns the signed exact integer reduced modulo 2^64, with both integer overflow and inexact set. For example, 2^63 gives 0x8000000000000000, 2^64 gives 0, 0x1.ccc×2^64 gives 0xccc0000000000000, and -1.5×2^63 gives 0x4000000000000000.
- R5: An all-ones exponent (infinity or any NaN, either sign) gives a result of 0 with only the invalid flag set.
- R6: Signed zeros give 0 with no flags. A nonzero subnormal, or any normal value of magnitude below 1, gives 0 with only inexact set.
- R7: Status word encoding: integer overflow is bit 57, inexact is bit 56 and invalid is bit 52. Every other bit of the status word is always 0.
- R8: `out_done` is high exactly in the cycle after a cycle with `in_valid` high. The result and status change only on such a capture and hold otherwise.
- R9: Valids on consecutive cycles each produce their own result on the following cycle, and `out_done` stays high throughout.
- R10: While `rst` is high and after it is released, the outputs are 0 and `out_done` is low until the first valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_bits | input | 64 | binary64 operand |
| out_done | output | 1 | Result valid pulse, one cycle after `in_valid` |
| out_value | output | 64 | Truncated integer, low 64 bits |
| out_status | output | 64 | Status word with flags at bits 57, 56 and 52 |

## Verification
A controller stuck in `ST_DONE` or `ST_WAIT` appears on `out_done` within one clock of the first valid or idle cycle. The per-cycle comparison against the bench model catches it immediately. A misplaced shift boundary or a faulty exception test changes `out_value` or a status flag one cycle after the affected operand is accepted. The boundaries are the exponent 52 transition, the 2^63 limit, the -2^63 exemption and shifts of 64 or more. The directed vectors cover each of these edges. The constrained random operands, concentrated near the integer range, expose wrong shift amounts there.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    // Status word flag positions (R7)
    localparam int STAT_IOV_POS = 57;
    localparam int STAT_INE_POS = 56;
    localparam int STAT_INV_POS = 52;
    localparam int STAT_W       = 64;

    typedef enum logic [1:0] {
        CLS_ZERO    = 2'd0,
        CLS_SUBNORM = 2'd1,
        CLS_NORMAL  = 2'd2,
        CLS_SPECIAL = 2'd3
    } fclass_e;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_DONE = 1'b1
    } conv_state_e;

    typedef struct packed {
        logic inv;
        logic iov;
        logic ine;
    } conv_flags_t;

endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W-1:0]  exp_f,
    input  logic [FRAC_W-1:0] frac_f,
    output fclass_e           cls,
    output logic [FRAC_W:0]   sig,
    output logic signed [EXP_W:0] uexp,
    output logic              frac_zero
);
    localparam int EW1  = EXP_W + 1;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    always_comb begin
        frac_zero = (frac_f == '0);
        sig       = {1'b1, frac_f};
        uexp      = $signed({1'b0, exp_f}) - $signed(EW1'(BIAS));
        if (exp_f == '1)
            cls = CLS_SPECIAL;
        else if (exp_f == '0)
            cls = frac_zero ? CLS_ZERO : CLS_SUBNORM;
        else
            cls = CLS_NORMAL;
    end
endmodule

// File: rtl/f2i_align.sv
module f2i_align #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64
) (
    input  logic [FRAC_W:0]       sig,
    input  logic signed [EXP_W:0] uexp,
    output logic [INT_W-1:0]      mag,
    output logic                  lost
);
    localparam int SW  = FRAC_W + 1;
    localparam int EW1 = EXP_W + 1;

    logic [EW1-1:0]   rsh;
    logic [EW1-1:0]   lsh;
    logic [INT_W-1:0] ext;
    logic [SW-1:0]    keep_mask;

    always_comb begin
        ext       = INT_W'(sig);
        rsh       = '0;
        lsh       = '0;
        keep_mask = '0;
        mag       = '0;
        lost      = 1'b0;
        if (uexp < 0) begin
            // magnitude below one: every significand bit is discarded
            lost = 1'b1;
        end else if (uexp < FRAC_W) begin
            rsh       = EW1'(FRAC_W) - EW1'(uexp);
            keep_mask = {SW{1'b1}} << rsh;
            mag       = INT_W'(sig >> rsh);
            lost      = |(sig & ~keep_mask);
        end else begin
            lsh = EW1'(uexp) - EW1'(FRAC_W);
            if (lsh < EW1'(INT_W))
                mag = ext << lsh;
        end
    end
endmodule

// File: rtl/f2i_finish.sv
module f2i_finish
    import f2i_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int INT_W = 64
) (
    input  logic                  sign,
    input  fclass_e               cls,
    input  logic signed [EXP_W:0] uexp,
    input  logic                  frac_zero,
    input  logic [INT_W-1:0]      mag,
    input  logic                  lost,
    output logic [INT_W-1:0]      value,
    output conv_flags_t           flags
);
    localparam int EW1 = EXP_W + 1;
    localparam logic signed [EW1-1:0] TOP_EXP = EW1'(INT_W - 1);

    logic big;
    logic min_exact;

    always_comb begin
        big       = (uexp >= TOP_EXP);
        min_exact = sign && (uexp == TOP_EXP) && frac_zero;  // R3
        value     = '0;
        flags     = '0;
        unique case (cls)
            CLS_SPECIAL: flags.inv = 1'b1;                    // R5
            CLS_ZERO:    flags     = '0;                      // R6
            CLS_SUBNORM: flags.ine = 1'b1;                    // R6
            CLS_NORMAL: begin
                value     = sign ? (~mag + 1'b1) : mag;       // R1 R2 R4
                flags.iov = big && !min_exact;                // R4
                flags.ine = lost || (big && !min_exact);
            end
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/f2i_trunc_conv.sv
module f2i_trunc_conv
    import f2i_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int INT_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [63:0]       in_bits,
    output logic              out_done,
    output logic [INT_W-1:0]  out_value,
    output logic [STAT_W-1:0] out_status
);
    localparam int OP_W = 1 + EXP_W + FRAC_W;

    conv_state_e           state, state_nxt;
    fclass_e               cls;
    logic [FRAC_W:0]       sig;
    logic signed [EXP_W:0] uexp;
    logic                  frac_zero;
    logic [INT_W-1:0]      mag;
    logic                  lost;
    logic [INT_W-1:0]      value_c;
    conv_flags_t           flags_c;
    logic [STAT_W-1:0]     status_c;

    f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_classify (
        .exp_f     (in_bits[OP_W-2 -: EXP_W]),
        .frac_f    (in_bits[FRAC_W-1:0]),
        .cls       (cls),
        .sig       (sig),
        .uexp      (uexp),
        .frac_zero (frac_zero)
    );

    f2i_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_align (
        .sig  (sig),
        .uexp (uexp),
        .mag  (mag),
        .lost (lost)
    );

    f2i_finish #(.EXP_W(EXP_W), .INT_W(INT_W)) u_finish (
        .sign      (in_bits[OP_W-1]),
        .cls       (cls),
        .uexp      (uexp),
        .frac_zero (frac_zero),
        .mag       (mag),
        .lost      (lost),
        .value     (value_c),
        .flags     (flags_c)
    );

    // R7: flags placed at fixed positions, other bits zero
    always_comb begin
        status_c               = '0;
        status_c[STAT_IOV_POS] = flags_c.iov;
        status_c[STAT_INE_POS] = flags_c.ine;
        status_c[STAT_INV_POS] = flags_c.inv;
    end

    // next-state logic (R8 R9)
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT: state_nxt = in_valid ? ST_DONE : ST_WAIT;
            ST_DONE: state_nxt = in_valid ? ST_DONE : ST_WAIT;
            default: state_nxt = ST_WAIT;
        endcase
    end

    // state register (R10)
    always_ff @(posedge clk) begin
        if (rst) state <= ST_WAIT;
        else     state <= state_nxt;
    end

    // output registers: capture on valid, hold otherwise (R8 R10)
    always_ff @(posedge clk) begin
        if (rst) begin
            out_value  <= '0;
            out_status <= '0;
        end else if (in_valid) begin
            out_value  <= value_c;
            out_status <= status_c;
        end
    end

    assign out_done = (state == ST_DONE);
endmodule

// File: rtl/f2i_trunc_conv_chk.sv
module f2i_trunc_conv_chk
    import f2i_pkg::*;
#(
    parameter int INT_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_done,
    input logic [INT_W-1:0]  out_value,
    input logic [STAT_W-1:0] out_status
);
    localparam logic [STAT_W-1:0] FLAG_MASK =
        (STAT_W'(1) << STAT_IOV_POS) | (STAT_W'(1) << STAT_INE_POS) |
        (STAT_W'(1) << STAT_INV_POS);

    assert_status_fields_R7: assert property (@(posedge clk) disable iff (rst)
        (out_status & ~FLAG_MASK) == '0);

    assert_invalid_alone_R5: assert property (@(posedge clk) disable iff (rst)
        out_status[STAT_INV_POS] |-> (out_value == '0) &&
            !out_status[STAT_IOV_POS] && !out_status[STAT_INE_POS]);

    assert_ovf_inexact_R4: assert property (@(posedge clk) disable iff (rst)
        out_status[STAT_IOV_POS] |-> out_status[STAT_INE_POS]);

    assert_done_after_valid_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_done);

    assert_no_stray_done_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_done);

    assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_value) && $stable(out_status));
endmodule

bind f2i_trunc_conv f2i_trunc_conv_chk #(.INT_W(INT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .out_done   (out_done),
    .out_value  (out_value),
    .out_status (out_status)
);

// File: tb/test_f2i_trunc_conv.sv
module test_f2i_trunc_conv;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_bits = '0;
    logic        out_done;
    logic [63:0] out_value;
    logic [63:0] out_status;

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;

    localparam logic [63:0] S_IOV = 64'h0200_0000_0000_0000;
    localparam logic [63:0] S_INE = 64'h0100_0000_0000_0000;
    localparam logic [63:0] S_INV = 64'h0010_0000_0000_0000;

    always #10 clk = ~clk;  // 50 MHz

    f2i_trunc_conv i_f2i_trunc_conv (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
        .out_done(out_done), .out_value(out_value), .out_status(out_status)
    );

    // behavioural reference: bit-by-bit weighting of the significand
    function automatic void ref_conv(input logic [63:0] b,
                                     output logic [63:0] r,
                                     output logic [63:0] s);
        int e;
        int u;
        int p;
        logic [63:0] m;
        logic [52:0] sg;
        bit inx;
        bit ovf;
        bit inv;
        e = int'(b[62:52]);
        m = '0; inx = 0; ovf = 0; inv = 0; r = '0;
        if (e == 2047) inv = 1;
        else if (e == 0) inx = (b[51:0] != 0);
        else begin
            sg = {1'b1, b[51:0]};
            u  = e - 1023;
            for (int i = 0; i < 53; i++) begin
                p = u - 52 + i;
                if (sg[i]) begin
                    if (p < 0) inx = 1;
                    else if (p < 64) m[p] = 1'b1;
                end
            end
            if (u >= 63 && !(b[63] && u == 63 && b[51:0] == 0)) ovf = 1;
            if (ovf) inx = 1;
            r = b[63] ? (~m + 64'd1) : m;
        end
        s = '0;
        s[57] = ovf; s[56] = inx; s[52] = inv;
    endfunction

    logic        m_done;
    logic [63:0] m_val;
    logic [63:0] m_st;

    always @(posedge clk) begin
        logic [63:0] tv;
        logic [63:0] ts;
        if (rst) begin
            m_done <= 1'b0; m_val <= '0; m_st <= '0;
        end else begin
            m_done <= in_valid;
            if (in_valid) begin
                ref_conv(in_bits, tv, ts);
                m_val <= tv; m_st <= ts;
            end
        end
    end

    // per-cycle comparison against the model (R8 R9)
    always @(negedge clk) begin
        if (armed) begin
            checks++;
            if (out_done !== m_done || out_value !== m_val || out_status !== m_st) begin
                errors++;
                $display("FAIL R8 cycle compare: got done=%0b %h %h expected done=%0b %h %h",
                         out_done, out_value, out_status, m_done, m_val, m_st);
            end
        end
    end

    task automatic check_out(input string tag, input logic [63:0] er,
                             input logic [63:0] es, input logic ed);
        checks++;
        if (out_done !== ed || out_value !== er || out_status !== es) begin
            errors++;
            $display("FAIL %s: got done=%0b %h %h expected done=%0b %h %h",
                     tag, out_done, out_value, out_status, ed, er, es);
        end
    endtask

    task automatic run_vec(input logic [63:0] b, input logic [63:0] er,
                           input logic [63:0] es, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_bits = b;
        @(negedge clk);
        in_valid = 1'b0; in_bits = '0;
        check_out(tag, er, es, 1'b1);
    endtask

    initial begin
        logic [63:0] held_v;
        logic [63:0] held_s;
        logic [63:0] rb;
        repeat (3) @(negedge clk);
        check_out("R10 in reset", '0, '0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check_out("R10 after reset", '0, '0, 1'b0);
        armed = 1'b1;

        run_vec(64'h3FF0_0000_0000_0000, 64'd1, '0, "R1 1.0");
        run_vec(64'hBFF0_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R1 -1.0");
        run_vec(64'h41F0_0000_0000_0000, 64'h0000_0001_0000_0000, '0, "R1 2^32");
        run_vec(64'h4340_0000_0000_0001, 64'h0020_0000_0000_0002, '0, "R1 2^53+2");
        run_vec(64'h3FF8_0000_0000_0000, 64'd1, S_INE, "R2 1.5");
        run_vec(64'hC006_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE, S_INE, "R2 -2.75");
        run_vec(64'hC3E0_0000_0000_0000, 64'h8000_0000_0000_0000, '0, "R3 -2^63");
        run_vec(64'h43E0_0000_0000_0000, 64'h8000_0000_0000_0000, S_IOV | S_INE, "R4 2^63");
        run_vec(64'h43F0_0000_0000_0000, 64'h0, S_IOV | S_INE, "R4 2^64");
        run_vec(64'h43FC_CC00_0000_0000, 64'hCCC0_0000_0000_0000, S_IOV | S_INE, "R4 0x1.cccp64");
        run_vec(64'hC3E8_0000_0000_0000, 64'h4000_0000_0000_0000, S_IOV | S_INE, "R4 -1.5*2^63");
        run_vec(64'h4C70_0000_0000_0000, 64'h0, S_IOV | S_INE, "R4 2^200");
        run_vec(64'h7FF0_0000_0000_0000, 64'h0, S_INV, "R5 +inf");
        run_vec(64'hFFF0_0000_0000_0001, 64'h0, S_INV, "R5 -nan");
        run_vec(64'h7FF8_0000_0000_0000, 64'h0, S_INV, "R5 qnan");
        run_vec(64'h0000_0000_0000_0000, 64'h0, '0, "R6 +0");
        run_vec(64'h8000_0000_0000_0000, 64'h0, '0, "R6 -0");
        run_vec(64'h0000_0000_0000_0001, 64'h0, S_INE, "R6 subnormal");
        run_vec(64'hBFE0_0000_0000_0000, 64'h0, S_INE, "R6 -0.5");

        // R8: hold and single done pulse
        run_vec(64'h4059_0000_0000_0000, 64'd100, '0, "R8 100.0");
        held_v = out_value; held_s = out_status;
        repeat (3) begin
            @(negedge clk);
            check_out("R8 hold", held_v, held_s, 1'b0);
        end

        // R9: back to back
        @(negedge clk);
        in_valid = 1'b1; in_bits = 64'h4000_0000_0000_0000;  // 2.0
        @(negedge clk);
        check_out("R9 first", 64'd2, '0, 1'b1);
        in_bits = 64'hC008_0000_0000_0000;                     // -3.0
        @(negedge clk);
        in_valid = 1'b0; in_bits = '0;
        check_out("R9 second", 64'hFFFF_FFFF_FFFF_FFFD, '0, 1'b1);

        // random operands, biased toward the integer range (R7 checked too)
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            rb = {$urandom, $urandom};
            if (k % 3 != 0) rb[62:52] = 11'(990 + ($urandom % 130));
            in_bits  = rb;
            in_valid = ($urandom % 4) != 0;
            checks++;
            if ((out_status & ~(S_IOV | S_INE | S_INV)) != 0) begin
                errors++;
                $display("FAIL R7 stray status bits: got %h expected none outside flags",
                         out_status);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule